// File: doc/BRIEF.md
# Circular Completion List Controller

This block runs two ring lists in local storage. The inbound ring holds request descriptors. The host fills each descriptor through the register window with a request address and a size. It then posts the index of the unit it has just filled. Whenever the controller's consumer index differs from that posted index, the controller steps forward one unit, with wrap, and presents the descriptor on a valid/ready request port. A request engine downstream takes each descriptor when it is ready.

When the engine finishes a request, it offers the request's flag word on a valid/ready completion port. The controller ORs a parameterised host-marker mask into that word. It writes the result into the next outbound unit and publishes that unit's index as a shadow pointer. It also latches an interrupt cause. The host polls the shadow pointer, compares it with its own saved read pointer N, reads unit N+1 and then writes its new read pointer back as an acknowledge. Both rings wrap at a programmable request count.

The register map uses byte offsets on a 12-bit address:
- 0x000: configuration (request count).
- 0x004: posted inbound index.
- 0x008: host acknowledge.
- 0x00C: shadow pointer (read-only).
- 0x010: cause, bit 0.
- 0x014: enable, bit 0.
- 0x100 + 8·i: inbound unit i address word.
- 0x104 + 8·i: inbound unit i size word.
- 0x200 + 4·i: outbound unit i (read-only).

Top module: `clc_top`

## Requirements
- R1: After reset, req_valid and irq are low, cpl_ready is high, the request count reads DEPTH, and the shadow pointer, posted index, acknowledge and all outbound units read 0.
- R2: A write to the configuration register takes bits [CW-1:0] as the request count. A value of 0, or a value above DEPTH, selects DEPTH. The register reads back the count in effect. The write also returns the consumer, posted, shadow and acknowledge pointers to 0.
- R3: Each inbound unit stores a request address with bits [4:0] forced to zero, because requests are 32-byte aligned. It also stores a size taken from the low SW bits of the size word. req_addr, req_size and req_idx present the stored values of the unit being offered.
- R4: The inbound ring is empty when the consumer index equals the posted index. Otherwise the unit offered is the one after the consumer index. The index wraps to 0 when incrementing it would reach the request count.
- R5: While req_valid is high and req_ready is low, req_valid stays high and the payload stays unchanged, unless a register write intervenes. The consumer index advances only on a req_valid and req_ready handshake.
- R6: On a cpl_valid and cpl_ready handshake, the word cpl_flag | HOST_MARK is written into outbound unit (shadow+1) mod count. The shadow pointer takes that index on the same clock edge.
- R7: cpl_ready is low while (shadow+1) mod count equals the host acknowledge pointer. While stalled, the shadow pointer and the outbound units do not change.
- R8: A completion handshake sets cause bit 0. Writing 1 to bit 0 of the cause register clears it, and writing 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R9: irq is high exactly while cause bit 0 and enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | output | 1 | Inbound descriptor available |
| req_ready | input | 1 | Request engine accepts descriptor |
| req_addr | output | AW | Request address, 32-byte aligned |
| req_size | output | SW | Request size |
| req_idx | output | IDXW | Inbound unit index of the descriptor |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Outbound ring has room |
| cpl_flag | input | 32 | Request flag word of the completion |
| irq | output | 1 | Outbound interrupt |

The request port follows valid/ready rules. The controller holds a descriptor until it is taken. The engine may keep req_ready low for any number of cycles. The completion port applies back-pressure only through the ring-full condition.

## Verification
The hardest state to reach from the ports is the outbound ring-full stall. The bench reaches it by shrinking the request count to 4 through the configuration register. It leaves the acknowledge pointer at 0 and issues three completions, so the next slot collides with the acknowledge pointer. It then holds cpl_valid high to confirm that the shadow pointer and unit 0 stay frozen. Finally it releases the stall by writing a new acknowledge and checks that the pending completion lands in unit 0 once the ring wraps. On the inbound side, the bench wraps the posted index past the count, so the consumer must step from unit 3 to unit 0.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam logic [11:0] OFS_CFG    = 12'h000;
  localparam logic [11:0] OFS_POST   = 12'h004;
  localparam logic [11:0] OFS_ACK    = 12'h008;
  localparam logic [11:0] OFS_SHADOW = 12'h00C;
  localparam logic [11:0] OFS_CAUSE  = 12'h010;
  localparam logic [11:0] OFS_ENABLE = 12'h014;
  localparam logic [3:0]  WIN_IN     = 4'h1;
  localparam logic [3:0]  WIN_OUT    = 4'h2;
endpackage

// File: rtl/clc_inlist.sv
module clc_inlist #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int IDXW  = 3,
  parameter int CW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [CW-1:0]   cnt,
  input  logic            unit_we,
  input  logic            unit_hi,
  input  logic [IDXW-1:0] unit_sel,
  input  logic [31:0]     wdata,
  input  logic            post_we,
  output logic [IDXW-1:0] post_q,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [SW-1:0]   req_size,
  output logic [IDXW-1:0] req_idx
);
  logic [AW-6:0]   addr_mem [DEPTH];
  logic [SW-1:0]   size_mem [DEPTH];
  logic [IDXW-1:0] cons_q, nxt;
  logic [CW-1:0]   inc;

  always_comb begin
    inc = {1'b0, cons_q} + CW'(1);
    nxt = (inc >= cnt) ? '0 : inc[IDXW-1:0];
  end

  assign req_valid = (cons_q != post_q);
  assign req_idx   = nxt;
  assign req_addr  = {addr_mem[nxt], 5'b0};
  assign req_size  = size_mem[nxt];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cons_q <= '0;
      post_q <= '0;
    end else begin
      if (post_we)                cons_q <= cons_q;
      if (post_we)                post_q <= wdata[IDXW-1:0];
      if (req_valid && req_ready) cons_q <= nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_mem[g] <= '0;
        size_mem[g] <= '0;
      end else if (unit_we && unit_sel == IDXW'(g)) begin
        if (unit_hi) size_mem[g] <= wdata[SW-1:0];
        else         addr_mem[g] <= wdata[AW-1:5];
      end
    end
  end
endmodule

// File: rtl/clc_outlist.sv
module clc_outlist #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3,
  parameter int CW    = 4,
  parameter logic [31:0] HOST_MARK = 32'hC000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [CW-1:0]   cnt,
  input  logic            ack_we,
  input  logic [IDXW-1:0] ack_wdata,
  output logic [IDXW-1:0] ack_q,
  output logic [IDXW-1:0] shadow_q,
  input  logic            cpl_valid,
  output logic            cpl_ready,
  input  logic [31:0]     cpl_flag,
  output logic            cpl_fire,
  input  logic [IDXW-1:0] rd_sel,
  output logic [31:0]     rd_word
);
  logic [31:0]     word_mem [DEPTH];
  logic [IDXW-1:0] nxt;
  logic [CW-1:0]   inc;

  always_comb begin
    inc = {1'b0, shadow_q} + CW'(1);
    nxt = (inc >= cnt) ? '0 : inc[IDXW-1:0];
  end

  assign cpl_ready = (nxt != ack_q);
  assign cpl_fire  = cpl_valid && cpl_ready;
  assign rd_word   = word_mem[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      shadow_q <= '0;
      ack_q    <= '0;
    end else begin
      if (ack_we)   ack_q    <= ack_wdata;
      if (cpl_fire) shadow_q <= nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                word_mem[g] <= '0;
      else if (cpl_fire && nxt == IDXW'(g))      word_mem[g] <= cpl_flag | HOST_MARK;
    end
  end
endmodule

// File: rtl/clc_irq.sv
module clc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_we,
  input  logic clr_bit,
  input  logic en_we,
  input  logic en_bit,
  output logic cause_q,
  output logic en_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (set)                  cause_q <= 1'b1;
      else if (clr_we && clr_bit) cause_q <= 1'b0;
      if (en_we)                en_q    <= en_bit;
    end
  end

  assign irq = cause_q & en_q;
endmodule

// File: rtl/clc_top.sv
module clc_top #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter logic [31:0] HOST_MARK = 32'hC000_0000,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [11:0]     reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [SW-1:0]   req_size,
  output logic [IDXW-1:0] req_idx,
  input  logic            cpl_valid,
  output logic            cpl_ready,
  input  logic [31:0]     cpl_flag,
  output logic            irq
);
  import clc_pkg::*;

  logic [CW-1:0]   cnt_q, cnt_wval;
  logic            wr_cfg, in_hit, out_hit, in_ok, out_ok;
  logic [IDXW-1:0] in_sel, out_sel, post_q, ack_q, shadow_q;
  logic [31:0]     out_word;
  logic            cpl_fire, cause_q, en_q;

  assign wr_cfg   = reg_wr && reg_addr == OFS_CFG;
  assign in_hit   = reg_addr[11:8] == WIN_IN;
  assign out_hit  = reg_addr[11:8] == WIN_OUT;
  assign in_sel   = reg_addr[IDXW+2:3];
  assign out_sel  = reg_addr[IDXW+1:2];
  assign in_ok    = {1'b0, in_sel} < CW'(DEPTH);
  assign out_ok   = {1'b0, out_sel} < CW'(DEPTH);
  assign cnt_wval = reg_wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= CW'(DEPTH);
    else if (wr_cfg) cnt_q <= (cnt_wval == '0 || cnt_wval > CW'(DEPTH)) ? CW'(DEPTH) : cnt_wval;
  end

  clc_inlist #(.DEPTH(DEPTH), .AW(AW), .SW(SW), .IDXW(IDXW), .CW(CW)) u_in (
    .clk(clk), .rst_n(rst_n), .clr(wr_cfg), .cnt(cnt_q),
    .unit_we(reg_wr && in_hit && in_ok), .unit_hi(reg_addr[2]), .unit_sel(in_sel),
    .wdata(reg_wdata), .post_we(reg_wr && reg_addr == OFS_POST), .post_q(post_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_idx(req_idx)
  );

  clc_outlist #(.DEPTH(DEPTH), .IDXW(IDXW), .CW(CW), .HOST_MARK(HOST_MARK)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(wr_cfg), .cnt(cnt_q),
    .ack_we(reg_wr && reg_addr == OFS_ACK), .ack_wdata(reg_wdata[IDXW-1:0]),
    .ack_q(ack_q), .shadow_q(shadow_q), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_flag(cpl_flag), .cpl_fire(cpl_fire), .rd_sel(out_sel), .rd_word(out_word)
  );

  clc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(cpl_fire),
    .clr_we(reg_wr && reg_addr == OFS_CAUSE), .clr_bit(reg_wdata[0]),
    .en_we(reg_wr && reg_addr == OFS_ENABLE), .en_bit(reg_wdata[0]),
    .cause_q(cause_q), .en_q(en_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (out_hit && out_ok) reg_rdata = out_word;
    else begin
      case (reg_addr)
        OFS_CFG:    reg_rdata = 32'(cnt_q);
        OFS_POST:   reg_rdata = 32'(post_q);
        OFS_ACK:    reg_rdata = 32'(ack_q);
        OFS_SHADOW: reg_rdata = 32'(shadow_q);
        OFS_CAUSE:  reg_rdata = {31'b0, cause_q};
        OFS_ENABLE: reg_rdata = {31'b0, en_q};
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/clc_top_chk.sv
module clc_top_chk #(
  parameter int AW   = 32,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [IDXW-1:0] req_idx,
  input logic            cpl_valid,
  input logic            cpl_ready,
  input logic            irq,
  input logic            cause_q,
  input logic [IDXW-1:0] shadow_q
);
  // R4
  empty_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !reg_wr) |=> !req_valid);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !reg_wr) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));
  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready && !reg_wr) |=> $stable(shadow_q));
  // R8
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready) |=> cause_q);
  // R9
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cpl_valid && cpl_ready) || $past(reg_wr)));
endmodule

bind clc_top clc_top_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_idx(req_idx), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .irq(irq), .cause_q(cause_q), .shadow_q(shadow_q)
);

// File: tb/clc_top_bench.sv
module clc_top_bench;
  localparam logic [31:0] MARK = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [15:0] req_size;
  logic [2:0]  req_idx;
  logic        cpl_valid = 1'b0, cpl_ready;
  logic [31:0] cpl_flag = '0;
  logic        irq;

  int checks = 0, errors = 0, consumed = 0;

  typedef struct packed { logic [31:0] a; logic [15:0] s; logic [2:0] i; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  clc_top u_clc_top (.*);

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  // driver: fill unit, post its index, push expected descriptor
  task automatic post(int unit, logic [31:0] a, logic [15:0] s);
    wr(12'h100 + 12'(unit * 8), a);
    wr(12'h104 + 12'(unit * 8), {16'h0, s});
    exp_q.push_back('{a: {a[31:5], 5'b0}, s: s, i: 3'(unit)});
    wr(12'h004, 32'(unit));
  endtask

  task automatic complete(logic [31:0] f);
    @(posedge clk); #1;
    cpl_valid = 1'b1; cpl_flag = f;
    forever begin
      @(negedge clk);
      if (cpl_ready) break;
    end
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  // monitor: compare descriptors as they are handed over (R3, R4)
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      consumed++;
      if (exp_q.size() == 0) check("R4 unexpected descriptor", 32'(req_idx), 32'hFFFF_FFFF);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check("R3 req_addr", req_addr, e.a);
        check("R3 req_size", 32'(req_size), 32'(e.s));
        check("R4 req_idx", 32'(req_idx), 32'(e.i));
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_valid", 32'(req_valid), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cpl_ready", 32'(cpl_ready), 1);
    rd(12'h000, d); check("R1 count", d, 8);
    rd(12'h00C, d); check("R1 shadow", d, 0);
    rd(12'h200, d); check("R1 outbound unit0", d, 0);

    // R2 count field
    wr(12'h000, 32'd4);
    rd(12'h000, d); check("R2 count 4", d, 4);

    // R3/R5 descriptors held while engine stalls
    post(1, 32'h1000_0013, 16'd64);
    post(2, 32'h2000_00FF, 16'd128);
    post(3, 32'h3000_0020, 16'd16);
    @(negedge clk);
    check("R5 valid held", 32'(req_valid), 1);
    check("R3 idx first", 32'(req_idx), 1);
    check("R3 addr aligned", req_addr, 32'h1000_0000);
    repeat (3) @(negedge clk);
    check("R5 payload stable", req_addr, 32'h1000_0000);
    @(posedge clk); #1 req_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 empty after drain", 32'(req_valid), 0);
    check("R4 consumed 3", 32'(consumed), 3);

    // R4 wrap past count 4: units 0 then 1
    post(0, 32'h4000_0041, 16'd8);
    post(1, 32'h5000_0000, 16'd4);
    repeat (4) @(negedge clk);
    check("R4 wrap consumed", 32'(consumed), 5);
    check("R4 queue drained", 32'(exp_q.size()), 0);

    // R6/R8/R9 completions
    wr(12'h000, 32'd4);
    complete(32'h11);
    rd(12'h204, d); check("R6 unit1 word", d, 32'h11 | MARK);
    rd(12'h00C, d); check("R6 shadow 1", d, 1);
    rd(12'h010, d); check("R8 cause set", d, 1);
    check("R9 irq masked", 32'(irq), 0);
    wr(12'h014, 32'd1);
    check("R9 irq enabled", 32'(irq), 1);
    complete(32'h22);
    complete(32'h33);
    rd(12'h00C, d); check("R6 shadow 3", d, 3);

    // R7 ring full with ack at 0
    @(negedge clk);
    check("R7 cpl_ready low", 32'(cpl_ready), 0);
    @(posedge clk); #1 cpl_valid = 1'b1; cpl_flag = 32'h44;
    repeat (3) @(negedge clk);
    rd(12'h00C, d); check("R7 shadow frozen", d, 3);
    rd(12'h200, d); check("R7 unit0 untouched", d, 0);
    wr(12'h008, 32'd2);
    @(negedge clk);
    @(posedge clk); #1 cpl_valid = 1'b0;
    rd(12'h200, d); check("R6 wrap unit0", d, 32'h44 | MARK);
    rd(12'h00C, d); check("R6 shadow wrap", d, 0);

    // R8 write-one-to-clear
    wr(12'h010, 32'd0);
    rd(12'h010, d); check("R8 zero write ignored", d, 1);
    wr(12'h010, 32'd1);
    rd(12'h010, d); check("R8 cleared", d, 0);
    check("R9 irq low", 32'(irq), 0);

    // R2 clamp and pointer reset
    wr(12'h000, 32'd0);
    rd(12'h000, d); check("R2 zero->DEPTH", d, 8);
    rd(12'h00C, d); check("R2 shadow reset", d, 0);
    rd(12'h008, d); check("R2 ack reset", d, 0);
    wr(12'h000, 32'd12);
    rd(12'h000, d); check("R2 over->DEPTH", d, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule